// File: doc/BRIEF.md
# DMA Channel Configuration Checker

This block sits in front of one channel of a DMA controller and decides, for each qualifying transfer request, whether a dual-address transfer may start. It looks at the source and destination addresses and their transfer-size codes, the auto-align setting and the channel-link fields. A clean configuration produces a one-cycle `go` pulse, and `start_clr` tells the control register to drop its software start bit. A bad configuration produces `blocked` instead, raises the sticky `cfg_err` status and, if enabled, a one-cycle interrupt pulse. No transfer is granted until software clears the error.

The decision is a five-state machine. `ST_IDLE` waits for a request. `ST_GRANT` is the one-cycle grant. `ST_REJECT` is the first refusal, which sets the error and carries the interrupt. `ST_DENY` is a later refusal while the error stays set. `ST_HALT` holds the error with no request pending. From `ST_IDLE` or `ST_GRANT`, a qualifying request moves to `ST_GRANT` if the configuration is clean and to `ST_REJECT` if it is not; with no request the machine returns to `ST_IDLE`. From `ST_REJECT`, `ST_DENY` or `ST_HALT`, `err_clear` moves to `ST_IDLE` before anything else is considered; failing that, a qualifying request moves to `ST_DENY`, and otherwise the machine goes to `ST_HALT`.

Top module: `dma_cfg_checker`

## Requirements
- R1: A request qualifies only when (`start_bit` or `ext_req_en`) and (`int_req` or `ext_req`) are both true; without a qualifying request neither `go` nor `blocked` rises.
- R2: A qualifying request with a clean configuration while `cfg_err` is low gives `go` high for exactly the next cycle.
- R3: `start_clr` is high in the same cycle as `go` if and only if `start_bit` was high when the request was taken.
- R4: Size codes demand alignment: 00 (4 bytes) needs address bits [1:0] zero, 01 (1 byte) needs nothing, 10 (2 bytes) needs bit 0 zero, 11 (16-byte line) needs bits [3:0] zero. With `auto_align` low, both addresses are checked against their own size codes.
- R5: With `auto_align` high, `aa_dst`=1 means only the source is checked and `aa_dst`=0 means only the destination is checked.
- R6: Link codes are 00 none, 01 step-then-end, 10 step, 11 end. With a non-zero code, `link_ch1` equal to `chan_id` is an error. With code 01, `link_ch2` equal to `chan_id` is also an error. `link_ch2` is ignored for codes 10 and 11, and both fields are ignored for code 00.
- R7: A qualifying request with a bad configuration gives `blocked` and `cfg_err` high in the next cycle, and no `go`.
- R8: `cfg_err` stays high until `err_clear`; while it is high, every qualifying request gives `blocked` in the next cycle and never `go`.
- R9: `irq` pulses for one cycle together with the first refusal, only when `irq_en` is high; later refusals raise no `irq`.
- R10: `err_clear` in the same cycle as a qualifying request while `cfg_err` is high: the clear wins, the request is dropped (no `go`, no `blocked` next cycle), and `cfg_err` is low in the next cycle.
- R11: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_addr | input | AW | Source address |
| dst_addr | input | AW | Destination address |
| src_size | input | 2 | Source size code |
| dst_size | input | 2 | Destination size code |
| auto_align | input | 1 | Auto-align enable |
| aa_dst | input | 1 | Auto-align acts on the destination (1) or the source (0) |
| link_mode | input | 2 | Link condition code |
| link_ch1 | input | CW | First link channel |
| link_ch2 | input | CW | Second link channel |
| chan_id | input | CW | Index of this channel |
| start_bit | input | 1 | Software start |
| ext_req_en | input | 1 | External request enable |
| int_req | input | 1 | Internal request |
| ext_req | input | 1 | External request |
| irq_en | input | 1 | Interrupt enable |
| err_clear | input | 1 | Software clear of the error status |
| go | output | 1 | Transfer granted (one cycle) |
| start_clr | output | 1 | Clear the start bit (with `go`) |
| blocked | output | 1 | Request refused (one cycle) |
| cfg_err | output | 1 | Sticky configuration error |
| irq | output | 1 | Error interrupt pulse |

## Verification
Two events can land in the same cycle: a software clear of the error and a new qualifying request. The bench forces this directly. It holds the error, then raises `err_clear` and `start_bit` with `int_req` in one cycle. It then expects `cfg_err`, `go` and `blocked` all low in the following cycle. A random phase also mixes clears and requests freely. The reference model gives the clear priority, so every such collision is compared against that rule.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        LNK_NONE      = 2'b00,
        LNK_STEP_END  = 2'b01,
        LNK_STEP      = 2'b10,
        LNK_END       = 2'b11
    } link_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRANT,
        ST_REJECT,
        ST_DENY,
        ST_HALT
    } chk_state_e;

    localparam int unsigned LOW_BITS = 4;

    // Low address bits that must be zero for a given size code.
    function automatic logic [LOW_BITS-1:0] size_mask(input xfer_size_e sz);
        unique case (sz)
            SZ_WORD: size_mask = 4'b0011;
            SZ_BYTE: size_mask = 4'b0000;
            SZ_HALF: size_mask = 4'b0001;
            SZ_LINE: size_mask = 4'b1111;
            default: size_mask = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/dma_align_chk.sv
module dma_align_chk
    import dma_cfg_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] addr,
    input  xfer_size_e    size,
    input  logic          check_en,
    output logic          misaligned
);
    localparam int unsigned PAD = AW - LOW_BITS;

    logic [AW-1:0] need_zero;

    always_comb begin
        need_zero  = {{PAD{1'b0}}, size_mask(size)};
        misaligned = check_en && (|(addr & need_zero));
    end

endmodule

// File: rtl/dma_link_chk.sv
module dma_link_chk
    import dma_cfg_pkg::*;
#(
    parameter int unsigned CW = 2
) (
    input  link_mode_e    mode,
    input  logic [CW-1:0] lch1,
    input  logic [CW-1:0] lch2,
    input  logic [CW-1:0] own_id,
    output logic          self_link
);
    logic use_first;
    logic use_second;

    always_comb begin
        use_first  = (mode != LNK_NONE);
        use_second = (mode == LNK_STEP_END);
        self_link  = (use_first  && (lch1 == own_id)) ||
                     (use_second && (lch2 == own_id));
    end

endmodule

// File: rtl/dma_cfg_checker.sv
module dma_cfg_checker
    import dma_cfg_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [1:0]    src_size,
    input  logic [1:0]    dst_size,
    input  logic          auto_align,
    input  logic          aa_dst,
    input  logic [1:0]    link_mode,
    input  logic [CW-1:0] link_ch1,
    input  logic [CW-1:0] link_ch2,
    input  logic [CW-1:0] chan_id,
    input  logic          start_bit,
    input  logic          ext_req_en,
    input  logic          int_req,
    input  logic          ext_req,
    input  logic          irq_en,
    input  logic          err_clear,
    output logic          go,
    output logic          start_clr,
    output logic          blocked,
    output logic          cfg_err,
    output logic          irq
);
    localparam int unsigned NPORT = 2;

    chk_state_e state_q, state_d;
    logic       sw_started_q;

    logic              req_valid;
    logic              cfg_ok;
    logic              link_bad;
    logic [NPORT-1:0]  mis;
    logic [NPORT-1:0]  chk_en;
    logic [AW-1:0]     addr_sel [NPORT];
    xfer_size_e        size_sel [NPORT];

    assign req_valid = (start_bit || ext_req_en) && (int_req || ext_req);

    // Port 0 is the source, port 1 the destination.
    assign addr_sel[0] = src_addr;
    assign addr_sel[1] = dst_addr;
    assign size_sel[0] = xfer_size_e'(src_size);
    assign size_sel[1] = xfer_size_e'(dst_size);
    assign chk_en[0]   = !auto_align || aa_dst;
    assign chk_en[1]   = !auto_align || !aa_dst;

    for (genvar p = 0; p < NPORT; p++) begin : g_align
        dma_align_chk #(.AW(AW)) u_align (
            .addr       (addr_sel[p]),
            .size       (size_sel[p]),
            .check_en   (chk_en[p]),
            .misaligned (mis[p])
        );
    end

    dma_link_chk #(.CW(CW)) u_link (
        .mode      (link_mode_e'(link_mode)),
        .lch1      (link_ch1),
        .lch2      (link_ch2),
        .own_id    (chan_id),
        .self_link (link_bad)
    );

    assign cfg_ok = !(|mis) && !link_bad;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_GRANT: begin
                if (req_valid) state_d = cfg_ok ? ST_GRANT : ST_REJECT;
                else           state_d = ST_IDLE;
            end
            ST_REJECT, ST_DENY, ST_HALT: begin
                if (err_clear)      state_d = ST_IDLE;
                else if (req_valid) state_d = ST_DENY;
                else                state_d = ST_HALT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Remembers whether the accepted request came from the software start bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sw_started_q <= 1'b0;
        else if ((state_q == ST_IDLE || state_q == ST_GRANT) && req_valid)
            sw_started_q <= start_bit;
    end

    // Outputs
    always_comb begin
        go        = 1'b0;
        start_clr = 1'b0;
        blocked   = 1'b0;
        cfg_err   = 1'b0;
        irq       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_GRANT: begin
                go        = 1'b1;
                start_clr = sw_started_q;
            end
            ST_REJECT: begin
                blocked = 1'b1;
                cfg_err = 1'b1;
                irq     = irq_en;
            end
            ST_DENY: begin
                blocked = 1'b1;
                cfg_err = 1'b1;
            end
            ST_HALT: cfg_err = 1'b1;
            default: ;
        endcase
    end

    // R2
    go_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> $past(req_valid && !(|mis)));

    // R3
    sclr_with_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |-> (go && $past(start_bit)));

    // R6
    link_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> $past(link_mode == LNK_NONE || link_ch1 != chan_id));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !err_clear) |=> cfg_err);

    // R8
    no_go_in_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !go);

    // R9
    irq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $rose(cfg_err));

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && err_clear) |=> (!cfg_err && !go && !blocked));

endmodule

// File: tb/dma_cfg_checker_test.sv
`timescale 1ns/1ps
module dma_cfg_checker_test;
    localparam int AW = 32;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] src_addr = '0, dst_addr = '0;
    logic [1:0]    src_size = 2'b01, dst_size = 2'b01;
    logic          auto_align = 1'b0, aa_dst = 1'b0;
    logic [1:0]    link_mode = 2'b00;
    logic [CW-1:0] link_ch1 = '0, link_ch2 = '0, chan_id = 2'd1;
    logic          start_bit = 1'b0, ext_req_en = 1'b0, int_req = 1'b0, ext_req = 1'b0;
    logic          irq_en = 1'b0, err_clear = 1'b0;
    logic          go, start_clr, blocked, cfg_err, irq;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    bit m_err = 0;
    bit e_go = 0, e_sclr = 0, e_blk = 0, e_irq_arm = 0;

    always #2 clk = ~clk;

    dma_cfg_checker #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .src_size(src_size), .dst_size(dst_size),
        .auto_align(auto_align), .aa_dst(aa_dst),
        .link_mode(link_mode), .link_ch1(link_ch1), .link_ch2(link_ch2),
        .chan_id(chan_id), .start_bit(start_bit), .ext_req_en(ext_req_en),
        .int_req(int_req), .ext_req(ext_req), .irq_en(irq_en),
        .err_clear(err_clear),
        .go(go), .start_clr(start_clr), .blocked(blocked),
        .cfg_err(cfg_err), .irq(irq)
    );

    function automatic int bytes_of(input logic [1:0] c);
        case (c)
            2'b00: return 4;
            2'b01: return 1;
            2'b10: return 2;
            default: return 16;
        endcase
    endfunction

    function automatic bit model_ok();
        bit chk_s, chk_d, ok;
        chk_s = (auto_align == 0) || (aa_dst == 1);
        chk_d = (auto_align == 0) || (aa_dst == 0);
        ok = 1;
        if (chk_s && (int'(src_addr[7:0]) % bytes_of(src_size) != 0)) ok = 0;
        if (chk_d && (int'(dst_addr[7:0]) % bytes_of(dst_size) != 0)) ok = 0;
        if (link_mode != 0 && link_ch1 == chan_id) ok = 0;
        if (link_mode == 1 && link_ch2 == chan_id) ok = 0;
        return ok;
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: update the model at the edge, compare all outputs just after it.
    task automatic step(input string tag);
        bit q;
        @(posedge clk);
        q = (start_bit || ext_req_en) && (int_req || ext_req);
        e_go = 0; e_sclr = 0; e_blk = 0; e_irq_arm = 0;
        if (!rst_n) begin
            m_err = 0;
        end else if (!m_err) begin
            if (q) begin
                if (model_ok()) begin
                    e_go = 1; e_sclr = start_bit;
                end else begin
                    m_err = 1; e_blk = 1; e_irq_arm = 1;
                end
            end
        end else begin
            if (err_clear) m_err = 0;
            else if (q)    e_blk = 1;
        end
        #1;
        check(tag, "go", go, e_go);
        check(tag, "start_clr", start_clr, e_sclr);
        check(tag, "blocked", blocked, e_blk);
        check(tag, "cfg_err", cfg_err, m_err);
        check(tag, "irq", irq, e_irq_arm && irq_en);
    endtask

    task automatic quiet();
        start_bit = 0; ext_req_en = 0; int_req = 0; ext_req = 0; err_clear = 0;
    endtask

    task automatic sw_req();
        start_bit = 1; int_req = 1; ext_req_en = 0; ext_req = 0;
    endtask

    task automatic good_cfg();
        src_addr = 32'h1000; dst_addr = 32'h2000; src_size = 2'b00; dst_size = 2'b00;
        auto_align = 0; aa_dst = 0; link_mode = 0; link_ch1 = 2'd0; link_ch2 = 2'd2; chan_id = 2'd1;
    endtask

    task automatic clear_err(input string tag);
        quiet(); err_clear = 1; step(tag); err_clear = 0; step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R11: reset
        good_cfg(); quiet();
        repeat (3) step("R11");
        #1 rst_n = 1;
        step("R11");

        // R1: partial request conditions
        start_bit = 1; step("R1"); quiet();
        int_req = 1; step("R1"); quiet();
        ext_req = 1; step("R1"); quiet();
        ext_req_en = 1; ext_req = 1; step("R1"); quiet(); step("R1");

        // R2 / R3: software start clears start bit; external path does not
        sw_req(); step("R2"); quiet(); step("R3");
        ext_req_en = 1; int_req = 1; step("R3"); quiet(); step("R2");
        sw_req(); repeat (3) step("R2"); quiet(); step("R2");

        // R4: every size code against every low address pattern, both sides
        for (int side = 0; side < 2; side++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int lo = 0; lo < 16; lo++) begin
                    good_cfg(); irq_en = lo[0];
                    if (side == 0) begin src_size = sz[1:0]; src_addr = 32'h400 + lo; end
                    else           begin dst_size = sz[1:0]; dst_addr = 32'h800 + lo; end
                    sw_req(); step("R4");
                    clear_err("R4");
                end
            end
        end

        // R5: auto-align selects which address is checked
        good_cfg(); auto_align = 1; aa_dst = 1; dst_addr = 32'h2003;
        sw_req(); step("R5"); clear_err("R5");
        good_cfg(); auto_align = 1; aa_dst = 1; src_addr = 32'h1002;
        sw_req(); step("R5"); clear_err("R5");
        good_cfg(); auto_align = 1; aa_dst = 0; src_addr = 32'h1001;
        sw_req(); step("R5"); clear_err("R5");
        good_cfg(); auto_align = 1; aa_dst = 0; dst_addr = 32'h2001;
        sw_req(); step("R5"); clear_err("R5");

        // R6: link fields against own index for every mode
        for (int md = 0; md < 4; md++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    good_cfg(); link_mode = md[1:0]; link_ch1 = a[1:0]; link_ch2 = b[1:0];
                    chan_id = 2'd2;
                    sw_req(); step("R6");
                    clear_err("R6");
                end
            end
        end

        // R7 / R8 / R9: first refusal with interrupt, later refusals without
        good_cfg(); src_addr = 32'h1001; irq_en = 1;
        sw_req(); step("R7");
        quiet(); step("R8");
        good_cfg(); sw_req(); step("R8"); step("R9");
        ext_req_en = 1; ext_req = 1; start_bit = 0; int_req = 0; step("R8");
        quiet(); repeat (3) step("R8");
        clear_err("R8");
        good_cfg(); src_addr = 32'h1001; irq_en = 0;
        sw_req(); step("R9"); quiet(); step("R9"); clear_err("R9");

        // R10: clear and a new request in the same cycle
        good_cfg(); dst_size = 2'b11; dst_addr = 32'h2004; irq_en = 1;
        sw_req(); step("R10");
        good_cfg(); sw_req(); err_clear = 1; step("R10");
        quiet(); step("R10");
        sw_req(); step("R10"); quiet(); step("R10");

        // Random mix, compared every clock
        for (int i = 0; i < 3000; i++) begin
            src_addr   = $urandom_range(0, 63);
            dst_addr   = $urandom_range(0, 63);
            src_size   = 2'($urandom_range(0, 3));
            dst_size   = 2'($urandom_range(0, 3));
            auto_align = 1'($urandom_range(0, 1));
            aa_dst     = 1'($urandom_range(0, 1));
            link_mode  = 2'($urandom_range(0, 3));
            link_ch1   = 2'($urandom_range(0, 3));
            link_ch2   = 2'($urandom_range(0, 3));
            chan_id    = 2'($urandom_range(0, 3));
            start_bit  = ($urandom_range(0, 2) == 0);
            ext_req_en = ($urandom_range(0, 2) == 0);
            int_req    = ($urandom_range(0, 1) == 0);
            ext_req    = ($urandom_range(0, 2) == 0);
            irq_en     = 1'($urandom_range(0, 1));
            err_clear  = ($urandom_range(0, 5) == 0);
            step("R10");
        end
        quiet(); step("R8");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule